// File: doc/BRIEF.md
# Exception state register unit

This block keeps the processor state that exception handling needs, in four 32-bit registers: an exception PC, a cause register, a status register and a bad-address register. Software reaches them through a register-file port selected by register number, with a combinational read and a write that takes effect at the clock edge. Exception control uses a separate entry strobe. The entry strobe captures the faulting PC and a cause code, and also the faulting memory address when the fault was a memory access. A return strobe restores the previous mode.

The status register holds a three-level stack of kernel/enable bit pairs and an 8-bit interrupt mask. Exception entry pushes a kernel-mode, interrupts-off pair onto the stack. Return pops it. Six interrupt request lines set sticky pending bits in the cause register whether or not interrupts are enabled. The block raises an interrupt request when a pending bit is unmasked and the current enable bit is set.

Every pin is a plain level or a single-cycle strobe. No stream flows through the block, so there is no valid/ready handshake and no back-pressure. A strobe is acted on in the cycle it is high, and the write port can always accept a write.

Top module: `exc_state_regs`

## Requirements
- R1: After reset, all four registers read 0 and `irq_req` is 0.
- R2: Register numbers map as follows: 8 is bad address, 12 is status, 13 is cause and 14 is exception PC. Any other number reads 0, and a write to it changes nothing.
- R3: Status bits 15:8 (mask) and 5:0 (stack) are writable. All other status bits read 0. Each stack pair has the enable bit at the even bit and the kernel/user bit at the odd bit: current is 1:0, previous is 3:2 and old is 5:4.
- R4: On `exc_take`, status bits 5:0 become the old bits 3:0 shifted up by two, with bits 1:0 cleared. The mask is unchanged.
- R5: On `exc_take`, the exception PC loads `exc_pc` and cause bits 5:2 load `exc_code`. Cause reads as {pending in 15:10, code in 5:2}, and every other bit reads 0.
- R6: On `exc_take` with `exc_mem` high, the bad-address register loads `exc_badaddr`. With `exc_mem` low, the bad-address register keeps its value.
- R7: On `exc_ret` without `exc_take`, status bits 5:0 become {old bits 5:4, old bits 5:2}. The mask is unchanged.
- R8: When an `irq_lines` bit i is high at a clock edge, cause bit 10+i is set. This happens whatever the enable bit and mask hold, and the bit stays set.
- R9: A software write to cause replaces pending bits 15:10 with write-data bits 15:10, ORed with any request that arrives in the same cycle. Writes leave the code in bits 5:2 unchanged.
- R10: `irq_req` = (OR over i of cause[10+i] AND status[10+i]) AND status[0].
- R11: While `exc_take` is high, a software write has no effect, and entry wins over `exc_ret`. While `exc_ret` is high, a software write to status has no effect, but writes to the other registers still apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Software write strobe |
| reg_num | input | 5 | Register number for read and write |
| reg_wdata | input | 32 | Software write data |
| reg_rdata | output | 32 | Read data for `reg_num` (combinational) |
| exc_take | input | 1 | Exception entry strobe |
| exc_pc | input | 32 | Address of the offending instruction |
| exc_code | input | 4 | Exception code for cause bits 5:2 |
| exc_mem | input | 1 | Entry is a memory fault; capture the bad address |
| exc_badaddr | input | 32 | Faulting memory address |
| exc_ret | input | 1 | Return-from-exception strobe |
| irq_lines | input | 6 | Interrupt request lines, one per pending bit |
| irq_req | output | 1 | An unmasked pending interrupt exists and interrupts are enabled |

## Verification
The embedded properties check on every cycle the following:
- the stack shift on entry and the pop on return;
- that the mask holds across both;
- that pending bits stay set unless software writes cause;
- that the code field changes only on entry;
- that the bad-address register holds unless a memory fault or a write reaches it;
- that `irq_req` never rises while the current enable bit is clear.

Only the bench scenarios show the following:
- full register values after mixed random sequences checked against a bench model;
- the readback of unmapped numbers and of write-masked status bits;
- the same-cycle priority between entry, return and software writes;
- a three-deep push followed by pops that duplicate the old pair.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int XLEN      = 32;
  localparam int REG_AW    = 5;
  localparam int STACK_LVL = 3;
  localparam int STACK_W   = 2 * STACK_LVL;
  localparam int MASK_LO   = 8;
  localparam int MASK_W    = 8;
  localparam int PEND_LO   = 10;
  localparam int PEND_W    = 6;
  localparam int CODE_LO   = 2;
  localparam int CODE_W    = 4;

  localparam logic [REG_AW-1:0] NUM_BAD  = 5'd8;
  localparam logic [REG_AW-1:0] NUM_STAT = 5'd12;
  localparam logic [REG_AW-1:0] NUM_CAUS = 5'd13;
  localparam logic [REG_AW-1:0] NUM_EPC  = 5'd14;

  typedef struct packed {
    logic wr_bad;
    logic wr_stat;
    logic wr_caus;
    logic wr_epc;
  } wr_sel_t;
endpackage

// File: rtl/exc_status_stack.sv
module exc_status_stack
  import exc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic            pop,
  input  logic            we,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] status_o
);
  logic [STACK_W-1:0] stk_q;
  logic [MASK_W-1:0]  mask_q;
  logic [STACK_W-1:0] push_v, pop_v;

  assign push_v = {stk_q[STACK_W-3:0], 2'b00};
  assign pop_v  = {stk_q[STACK_W-1 -: 2], stk_q[STACK_W-1:2]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stk_q  <= '0;
      mask_q <= '0;
    end else if (push) begin
      stk_q <= push_v;
    end else if (pop) begin
      stk_q <= pop_v;
    end else if (we) begin
      stk_q  <= wdata[STACK_W-1:0];
      mask_q <= wdata[MASK_LO +: MASK_W];
    end
  end

  always_comb begin
    status_o = '0;
    status_o[STACK_W-1:0] = stk_q;
    status_o[MASK_LO +: MASK_W] = mask_q;
  end

  // R4: push shifts the stack up and enters kernel mode with interrupts off
  p_push_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (status_o[STACK_W-1:0] == {$past(status_o[STACK_W-3:0]), 2'b00}));
  p_push_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> $stable(status_o[MASK_LO +: MASK_W]));
  // R7: pop restores the previous pair and duplicates the old pair
  p_pop_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> (status_o[STACK_W-3:0] == $past(status_o[STACK_W-1:2])) &&
                       (status_o[STACK_W-1 -: 2] == $past(status_o[STACK_W-1 -: 2])));
  p_pop_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> $stable(status_o[MASK_LO +: MASK_W]));
endmodule

// File: rtl/exc_cause_pend.sv
module exc_cause_pend
  import exc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [CODE_W-1:0] code_in,
  input  logic              we,
  input  logic [XLEN-1:0]   wdata,
  input  logic [PEND_W-1:0] irq_in,
  output logic [XLEN-1:0]   cause_o,
  output logic [PEND_W-1:0] pend_o
);
  logic [CODE_W-1:0] code_q;
  logic [PEND_W-1:0] pend_q;
  logic [PEND_W-1:0] pend_base;

  assign pend_base = we ? wdata[PEND_LO +: PEND_W] : pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= '0;
      pend_q <= '0;
    end else begin
      pend_q <= pend_base | irq_in;
      if (take) code_q <= code_in;
    end
  end

  always_comb begin
    cause_o = '0;
    cause_o[CODE_LO +: CODE_W] = code_q;
    cause_o[PEND_LO +: PEND_W] = pend_q;
  end
  assign pend_o = pend_q;

  // R8: pending bits are sticky unless software writes cause
  p_pend_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ((pend_o & $past(pend_o)) == $past(pend_o)));
  // R8: a request line sets its bit at the next edge
  p_pend_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_o & $past(irq_in)) == $past(irq_in)));
  // R9: the code field changes only on exception entry
  p_code_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(cause_o[CODE_LO +: CODE_W]));
endmodule

// File: rtl/exc_addr_regs.sv
module exc_addr_regs
  import exc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic            mem_fault,
  input  logic [XLEN-1:0] pc_in,
  input  logic [XLEN-1:0] bad_in,
  input  logic            we_epc,
  input  logic            we_bad,
  input  logic [XLEN-1:0] wdata,
  output logic [XLEN-1:0] epc_o,
  output logic [XLEN-1:0] bad_o
);
  logic [XLEN-1:0] epc_q, bad_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epc_q <= '0;
      bad_q <= '0;
    end else begin
      if (take)        epc_q <= pc_in;
      else if (we_epc) epc_q <= wdata;
      if (take && mem_fault) bad_q <= bad_in;
      else if (we_bad)       bad_q <= wdata;
    end
  end

  assign epc_o = epc_q;
  assign bad_o = bad_q;

  // R5: entry captures the faulting PC
  p_epc_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (epc_o == $past(pc_in)));
  // R6: the bad address holds unless a memory fault or a write reaches it
  p_bad_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!(take && mem_fault) && !we_bad) |=> $stable(bad_o));
endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
  import exc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_num,
  input  logic [XLEN-1:0]   reg_wdata,
  output logic [XLEN-1:0]   reg_rdata,
  input  logic              exc_take,
  input  logic [XLEN-1:0]   exc_pc,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              exc_mem,
  input  logic [XLEN-1:0]   exc_badaddr,
  input  logic              exc_ret,
  input  logic [PEND_W-1:0] irq_lines,
  output logic              irq_req
);
  wr_sel_t           sel;
  logic              sw_ok;
  logic [XLEN-1:0]   status_w, cause_w, epc_w, bad_w;
  logic [PEND_W-1:0] pend_w;

  assign sw_ok = reg_we && !exc_take;

  always_comb begin
    sel.wr_bad  = sw_ok && (reg_num == NUM_BAD);
    sel.wr_stat = sw_ok && !exc_ret && (reg_num == NUM_STAT);
    sel.wr_caus = sw_ok && (reg_num == NUM_CAUS);
    sel.wr_epc  = sw_ok && (reg_num == NUM_EPC);
  end

  exc_status_stack u_stat (
    .clk(clk), .rst_n(rst_n), .push(exc_take), .pop(exc_ret),
    .we(sel.wr_stat), .wdata(reg_wdata), .status_o(status_w)
  );

  exc_cause_pend u_caus (
    .clk(clk), .rst_n(rst_n), .take(exc_take), .code_in(exc_code),
    .we(sel.wr_caus), .wdata(reg_wdata), .irq_in(irq_lines),
    .cause_o(cause_w), .pend_o(pend_w)
  );

  exc_addr_regs u_addr (
    .clk(clk), .rst_n(rst_n), .take(exc_take), .mem_fault(exc_mem),
    .pc_in(exc_pc), .bad_in(exc_badaddr), .we_epc(sel.wr_epc),
    .we_bad(sel.wr_bad), .wdata(reg_wdata), .epc_o(epc_w), .bad_o(bad_w)
  );

  always_comb begin
    unique case (reg_num)
      NUM_BAD:  reg_rdata = bad_w;
      NUM_STAT: reg_rdata = status_w;
      NUM_CAUS: reg_rdata = cause_w;
      NUM_EPC:  reg_rdata = epc_w;
      default:  reg_rdata = '0;
    endcase
  end

  assign irq_req = (|(pend_w & status_w[PEND_LO +: PEND_W])) & status_w[0];

  // R10: no request while the current enable bit is clear or nothing is pending
  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (status_w[0] && (|pend_w)));
  // R11: entry suppresses software writes to the exception PC
  p_take_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_take && reg_we && reg_num == NUM_EPC) |=> (epc_w == $past(exc_pc)));
endmodule

// File: tb/sim_exc_state_regs.sv
module sim_exc_state_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_num = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        exc_take = 1'b0;
  logic [31:0] exc_pc = '0;
  logic [3:0]  exc_code = '0;
  logic        exc_mem = 1'b0;
  logic [31:0] exc_badaddr = '0;
  logic        exc_ret = 1'b0;
  logic [5:0]  irq_lines = '0;
  logic        irq_req;

  int checks = 0;
  int errors = 0;

  // bench model state
  logic [31:0] m_stat, m_epc, m_bad;
  logic [3:0]  m_code;
  logic [5:0]  m_pend;

  always #10 clk = ~clk;

  exc_state_regs u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_num(reg_num),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .exc_take(exc_take),
    .exc_pc(exc_pc), .exc_code(exc_code), .exc_mem(exc_mem),
    .exc_badaddr(exc_badaddr), .exc_ret(exc_ret), .irq_lines(irq_lines),
    .irq_req(irq_req)
  );

  function automatic logic [31:0] cause_val(input logic [5:0] p, input logic [3:0] c);
    return {16'b0, p, 4'b0, c, 2'b0};
  endfunction

  function automatic logic irq_val(input logic [31:0] s, input logic [5:0] p);
    return (|(p & s[15:10])) & s[0];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // advance the model by the inputs now on the pins
  task automatic model_step();
    logic wr;
    wr = reg_we && !exc_take;
    if (exc_take) m_stat[5:0] = {m_stat[3:0], 2'b00};
    else if (exc_ret) m_stat[5:0] = {m_stat[5:4], m_stat[5:2]};
    else if (wr && reg_num == 5'd12) m_stat = reg_wdata & 32'h0000FF3F;
    if (exc_take) m_code = exc_code;
    m_pend = ((wr && reg_num == 5'd13) ? reg_wdata[15:10] : m_pend) | irq_lines;
    if (exc_take) m_epc = exc_pc;
    else if (wr && reg_num == 5'd14) m_epc = reg_wdata;
    if (exc_take && exc_mem) m_bad = exc_badaddr;
    else if (wr && reg_num == 5'd8) m_bad = reg_wdata;
  endtask

  // inputs already driven after a negedge; clock them in, then release strobes
  task automatic tick();
    @(posedge clk);
    model_step();
    #1;
    reg_we = 0; exc_take = 0; exc_ret = 0; irq_lines = '0; exc_mem = 0;
  endtask

  task automatic read_all();
    reg_num = 5'd8;  #1; chk("R6 bad address", reg_rdata, m_bad);
    reg_num = 5'd12; #1; chk("R4 R7 status", reg_rdata, m_stat);
    reg_num = 5'd13; #1; chk("R9 cause", reg_rdata, cause_val(m_pend, m_code));
    reg_num = 5'd14; #1; chk("R5 exception PC", reg_rdata, m_epc);
    chk("R10 irq_req", {31'b0, irq_req}, {31'b0, irq_val(m_stat, m_pend)});
  endtask

  task automatic sw_write(input logic [4:0] n, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_num = n; reg_wdata = d;
    tick();
  endtask

  task automatic enter(input logic [31:0] pc, input logic [3:0] c, input logic mem,
                       input logic [31:0] ba);
    @(negedge clk);
    exc_take = 1; exc_pc = pc; exc_code = c; exc_mem = mem; exc_badaddr = ba;
    tick();
  endtask

  task automatic leave();
    @(negedge clk);
    exc_ret = 1;
    tick();
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_stat = '0; m_epc = '0; m_bad = '0; m_code = '0; m_pend = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    // R1 reset state
    reg_num = 5'd8;  #1; chk("R1 reset bad", reg_rdata, 32'h0);
    reg_num = 5'd12; #1; chk("R1 reset status", reg_rdata, 32'h0);
    reg_num = 5'd13; #1; chk("R1 reset cause", reg_rdata, 32'h0);
    reg_num = 5'd14; #1; chk("R1 reset epc", reg_rdata, 32'h0);
    chk("R1 reset irq_req", {31'b0, irq_req}, 32'h0);

    // R2 unmapped number: write ignored, reads 0
    sw_write(5'd9, 32'hFFFF_FFFF);
    reg_num = 5'd9; #1; chk("R2 unmapped read", reg_rdata, 32'h0);
    reg_num = 5'd0; #1; chk("R2 number 0 read", reg_rdata, 32'h0);
    read_all();

    // R3 status write masking
    sw_write(5'd12, 32'hFFFF_FFFF);
    reg_num = 5'd12; #1; chk("R3 status writable bits", reg_rdata, 32'h0000FF3F);
    read_all();

    // R9 code bits not writable by software; pending set by write
    sw_write(5'd13, 32'hFFFF_FFFF);
    reg_num = 5'd13; #1; chk("R9 cause write ignores code", reg_rdata, 32'h0000FC00);
    read_all();
    sw_write(5'd13, 32'h0);
    read_all();

    // R8 pending set while disabled, sticky
    sw_write(5'd12, 32'h0000FF00);
    @(negedge clk); irq_lines = 6'b000100; tick();
    reg_num = 5'd13; #1; chk("R8 pending while disabled", reg_rdata, 32'h0000_1000);
    chk("R10 no request while disabled", {31'b0, irq_req}, 32'h0);
    repeat (2) @(negedge clk);
    reg_num = 5'd13; #1; chk("R8 pending sticky", reg_rdata, 32'h0000_1000);
    sw_write(5'd12, 32'h0000_1001);
    chk("R10 request when enabled", {31'b0, irq_req}, 32'h1);
    sw_write(5'd12, 32'h0000_0801);
    chk("R10 masked level", {31'b0, irq_req}, 32'h0);

    // R4 R7 three-deep push and pops
    sw_write(5'd12, 32'h0000_AB3D);
    enter(32'h0000_1000, 4'd12, 1'b0, 32'hDEAD_BEEF);
    read_all();
    reg_num = 5'd12; #1; chk("R4 push one", reg_rdata, 32'h0000_AB34);
    chk("R6 no bad update on non-memory fault", m_bad, 32'h0);
    reg_num = 5'd8; #1; chk("R6 bad held", reg_rdata, 32'h0);
    enter(32'h0000_2004, 4'd4, 1'b1, 32'h0BAD_0ADD);
    read_all();
    reg_num = 5'd8; #1; chk("R6 bad captured", reg_rdata, 32'h0BAD_0ADD);
    enter(32'h0000_3008, 4'd10, 1'b0, 32'h0);
    read_all();
    reg_num = 5'd13; #1; chk("R5 code 10 captured", reg_rdata[5:2], 32'd10);
    leave(); read_all();
    leave(); read_all();
    leave(); read_all();
    reg_num = 5'd12; #1; chk("R7 pops duplicate old pair", reg_rdata, 32'h0000_AB00);

    // R11 priorities
    @(negedge clk);
    exc_take = 1; exc_ret = 1; exc_pc = 32'h4444_0000; exc_code = 4'd8;
    reg_we = 1; reg_num = 5'd14; reg_wdata = 32'h1234_5678;
    tick();
    reg_num = 5'd14; #1; chk("R11 take beats write", reg_rdata, 32'h4444_0000);
    read_all();
    sw_write(5'd12, 32'h0000_0015);
    @(negedge clk);
    exc_ret = 1; reg_we = 1; reg_num = 5'd12; reg_wdata = 32'h0000_FF3F;
    tick();
    reg_num = 5'd12; #1; chk("R11 return beats status write", reg_rdata, 32'h0000_0015);
    @(negedge clk);
    exc_ret = 1; reg_we = 1; reg_num = 5'd8; reg_wdata = 32'hCAFE_0001;
    tick();
    reg_num = 5'd8; #1; chk("R11 other write during return", reg_rdata, 32'hCAFE_0001);
    read_all();

    // constrained random mix
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      exc_take = ($urandom_range(0, 7) == 0);
      exc_ret  = ($urandom_range(0, 7) == 0);
      exc_pc = $urandom; exc_code = 4'($urandom_range(0, 15));
      exc_mem = $urandom_range(0, 1) == 1; exc_badaddr = $urandom;
      reg_we = ($urandom_range(0, 2) == 0);
      case ($urandom_range(0, 4))
        0: reg_num = 5'd8;
        1: reg_num = 5'd12;
        2: reg_num = 5'd13;
        3: reg_num = 5'd14;
        default: reg_num = 5'($urandom_range(0, 31));
      endcase
      reg_wdata = $urandom;
      if (reg_num == 5'd12 && $urandom_range(0, 1) == 1) reg_wdata[0] = 1'b1;
      irq_lines = ($urandom_range(0, 5) == 0) ? 6'($urandom) : 6'b0;
      tick();
      read_all();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule